// File: doc/BRIEF.md
# Scatter-Gather Memory-to-Stream Engine

This block follows a linked list of descriptors in memory and sends the buffer of each descriptor out as packet data. It reads descriptors and buffer words, and writes completion status back, through one request/response memory port. A descriptor holds a next pointer, a buffer address, a control word with a byte length and packet-boundary flags, a status word, and five application words. A packet can span several descriptors. When a descriptor opens a packet, its five application words go out first on a separate control stream.

Software loads the current-descriptor pointer, sets the engine running, and writes the tail-descriptor pointer. The engine then processes descriptors one at a time. After each one it writes the status word and follows the next pointer. It stops and reports idle once it has handled the tail descriptor. It stops and reports halted if it fetches a descriptor that is already marked complete. A later write to the tail register restarts the walk from wherever the current pointer rests.

Top module: `sg_mm2s_engine`

## Requirements
- R1: After reset, halted is 1, idle is 0, the current pointer is 0, and no memory request or stream beat is valid.
- R2: A configuration write with the run bit set clears halted and idle. A walk starts only while run is 1, halted is 0 and idle is 0.
- R3: Before anything else, the engine reads the status word at byte offset 28. If its bit 31 is set, the engine sets halted and stops. In that case it emits no stream beat, writes nothing back and leaves the current pointer unchanged.
- R4: When bit 27 of the control word (offset 24) is set, the engine sends the five words at offsets 32, 36, 40, 44 and 48 on the control stream, in that order. Last is set on the fifth word only. These words go out before any data beat of that descriptor.
- R5: Control bits 22:0 give the length in bytes. The engine emits ceil(length/4) data beats, read in ascending order from the buffer address in the low word at offset 8. A zero length emits no beat.
- R6: On the final beat of a descriptor, keep is 0x1, 0x3 or 0x7 when length mod 4 is 1, 2 or 3, and 0xF when it is 0. Every other beat has keep 0xF.
- R7: The final data beat has last set only when control bit 26 (end of packet) is set. pkt_done pulses for exactly one cycle for each end-of-packet descriptor.
- R8: After each descriptor, the engine writes the length ORed with 0x80000000 to that descriptor's status word.
- R9: After each descriptor, the current pointer takes the low next-pointer word at offset 0. If the descriptor just handled was the tail, idle becomes 1 and the walk stops.
- R10: A tail write clears idle. The walk then resumes from the current pointer and runs up to the new tail.
- R11: Once a data or control beat is valid, it stays valid with unchanged contents until ready accepts it.
- R12: While run is 0, a tail write starts no descriptor processing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_run | input | 1 | Run bit written by cfg_wr |
| cur_wr | input | 1 | Load strobe for the current-descriptor pointer |
| cur_wdata | input | ADDR_W | New current-descriptor pointer |
| tail_wr | input | 1 | Tail-descriptor write strobe (also starts the walk) |
| tail_wdata | input | ADDR_W | New tail-descriptor pointer |
| cur_ptr | output | ADDR_W | Current-descriptor pointer |
| st_halted | output | 1 | Halted flag |
| st_idle | output | 1 | Idle flag |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | ADDR_W | Byte address, word aligned |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_rdata | input | 32 | Read response data |
| dout_valid | output | 1 | Data beat valid |
| dout_ready | input | 1 | Data sink ready |
| dout_data | output | 32 | Data word |
| dout_keep | output | 4 | Byte enables of the data word |
| dout_last | output | 1 | Final beat of a packet |
| cout_valid | output | 1 | Control beat valid |
| cout_ready | input | 1 | Control sink ready |
| cout_data | output | 32 | Application word |
| cout_last | output | 1 | Fifth application word |
| pkt_done | output | 1 | One-cycle pulse per completed packet |

## Verification
A stream beat becomes visible on the cycle after the read response that carries it. It is consumed on the clock edge at which ready is high. The bench therefore makes ready decisions at the falling edge and checks a beat at the same falling edge at which it commits to accepting it. It also checks, one falling edge later, that a stalled beat is still present and unchanged. Status words, the current pointer, pkt_done counts and the halted and idle flags settle some time after a tail or configuration write. These are checked only after the idle flag is seen, or after a fixed wait when the walk must not start, so no check depends on how many cycles a memory access takes.

// File: rtl/sg_pkg.sv
package sg_pkg;

  // Byte offsets inside a descriptor
  localparam int OFF_NEXT = 0;
  localparam int OFF_BUF  = 8;
  localparam int OFF_CTRL = 24;
  localparam int OFF_STAT = 28;
  localparam int OFF_APP  = 32;

  // Bit positions in control / status words
  localparam int BIT_EOP  = 26;
  localparam int BIT_SOP  = 27;
  localparam int BIT_DONE = 31;

  typedef enum logic [2:0] {
    W_IDLE, W_RD, W_RSP, W_COUT, W_DOUT, W_WB
  } walk_st_t;

  typedef enum logic [2:0] {
    P_STAT, P_CTRL, P_NEXT, P_BUF, P_APP, P_DATA
  } phase_t;

  // Byte enables of the closing word given length mod 4
  function automatic logic [3:0] tail_keep(input logic [1:0] rem);
    case (rem)
      2'd1:    return 4'b0001;
      2'd2:    return 4'b0011;
      2'd3:    return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/sg_chan_regs.sv
module sg_chan_regs #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_run,
  input  logic              cur_wr,
  input  logic [ADDR_W-1:0] cur_wdata,
  input  logic              tail_wr,
  input  logic [ADDR_W-1:0] tail_wdata,
  input  logic              adv,
  input  logic [ADDR_W-1:0] adv_next,
  input  logic              halt_req,
  output logic [ADDR_W-1:0] cur_ptr,
  output logic              at_tail,
  output logic              run_ok,
  output logic              halted,
  output logic              idle
);

  logic              run_q;
  logic [ADDR_W-1:0] tail_q;

  assign at_tail = (cur_ptr == tail_q);
  assign run_ok  = run_q && !halted && !idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      halted  <= 1'b1;
      idle    <= 1'b0;
      cur_ptr <= '0;
      tail_q  <= '0;
    end else begin
      if (halt_req) halted <= 1'b1;
      if (cfg_wr) begin
        run_q <= cfg_run;
        if (cfg_run) begin
          halted <= 1'b0;
          idle   <= 1'b0;
        end
      end
      if (cur_wr) cur_ptr <= cur_wdata;
      if (adv) begin
        cur_ptr <= adv_next;
        if (at_tail) idle <= 1'b1;
      end
      if (tail_wr) begin
        tail_q <= tail_wdata;
        idle   <= 1'b0;
      end
    end
  end

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted && !cfg_wr |=> halted); // R3

  AST_TAIL_STOPS: assert property (@(posedge clk) disable iff (rst)
    adv && at_tail && !tail_wr |=> idle); // R9

  AST_TAIL_WAKES: assert property (@(posedge clk) disable iff (rst)
    tail_wr |=> !idle); // R10

  AST_PTR_QUIET: assert property (@(posedge clk) disable iff (rst)
    !adv && !cur_wr |=> $stable(cur_ptr)); // R3

endmodule

// File: rtl/sg_walker.sv
module sg_walker
  import sg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 23,
  parameter int APP_WORDS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_ok,
  input  logic              at_tail,
  input  logic [ADDR_W-1:0] cur_ptr,
  output logic              adv,
  output logic [ADDR_W-1:0] adv_next,
  output logic              halt_req,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_rdata,
  output logic              dout_valid,
  input  logic              dout_ready,
  output logic [31:0]       dout_data,
  output logic [3:0]        dout_keep,
  output logic              dout_last,
  output logic              cout_valid,
  input  logic              cout_ready,
  output logic [31:0]       cout_data,
  output logic              cout_last,
  output logic              pkt_done
);

  localparam logic [ADDR_W-1:0] A_NEXT = ADDR_W'(OFF_NEXT);
  localparam logic [ADDR_W-1:0] A_BUF  = ADDR_W'(OFF_BUF);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_APP  = ADDR_W'(OFF_APP);
  localparam logic [LEN_W-1:0]  APP_LAST = LEN_W'(APP_WORDS - 1);

  walk_st_t          st, st_n;
  phase_t            ph, ph_n;
  logic [LEN_W-1:0]  idx, idx_n;
  logic [LEN_W-1:0]  len_q, len_n;
  logic              sop_q, sop_n, eop_q, eop_n;
  logic [ADDR_W-1:0] nxt_q, nxt_n, buf_q, buf_n;

  logic              rv_n, rwe_n;
  logic [ADDR_W-1:0] ra_n;
  logic [31:0]       rwd_n;
  logic              dv_n, dl_n, cv_n, cl_n, pd_n;
  logic [31:0]       dd_n, cd_n;
  logic [3:0]        dk_n;

  logic              go_rd, go_wb, go_data;
  logic [ADDR_W-1:0] rd_addr;
  phase_t            rd_ph;

  logic [LEN_W-1:0]  nwords;
  logic              fin;
  logic [LEN_W-1:0]  idx_inc;
  logic [ADDR_W-1:0] word_off;

  assign nwords   = LEN_W'(({1'b0, len_q} + (LEN_W+1)'(3)) >> 2);
  assign fin      = (idx == nwords - 1'b1);
  assign idx_inc  = idx + 1'b1;
  assign word_off = ADDR_W'({idx_inc, 2'b00});
  assign adv_next = nxt_q;

  always_comb begin
    st_n = st;  ph_n = ph;  idx_n = idx;
    len_n = len_q;  sop_n = sop_q;  eop_n = eop_q;
    nxt_n = nxt_q;  buf_n = buf_q;
    rv_n = mem_req_valid;  rwe_n = mem_req_we;
    ra_n = mem_req_addr;   rwd_n = mem_req_wdata;
    dv_n = dout_valid;  dd_n = dout_data;  dk_n = dout_keep;  dl_n = dout_last;
    cv_n = cout_valid;  cd_n = cout_data;  cl_n = cout_last;
    pd_n = 1'b0;
    halt_req = 1'b0;
    adv      = 1'b0;
    go_rd = 1'b0;  go_wb = 1'b0;  go_data = 1'b0;
    rd_addr = '0;  rd_ph = ph;

    case (st)
      W_IDLE: begin
        if (run_ok) begin
          go_rd = 1'b1;  rd_addr = cur_ptr + A_STAT;  rd_ph = P_STAT;
        end
      end
      W_RD: begin
        if (mem_req_ready) begin
          rv_n = 1'b0;
          st_n = W_RSP;
        end
      end
      W_RSP: begin
        if (mem_rsp_valid) begin
          case (ph)
            P_STAT: begin
              if (mem_rsp_rdata[BIT_DONE]) begin
                halt_req = 1'b1;
                st_n     = W_IDLE;
              end else begin
                go_rd = 1'b1;  rd_addr = cur_ptr + A_CTRL;  rd_ph = P_CTRL;
              end
            end
            P_CTRL: begin
              len_n = mem_rsp_rdata[LEN_W-1:0];
              sop_n = mem_rsp_rdata[BIT_SOP];
              eop_n = mem_rsp_rdata[BIT_EOP];
              go_rd = 1'b1;  rd_addr = cur_ptr + A_NEXT;  rd_ph = P_NEXT;
            end
            P_NEXT: begin
              nxt_n = mem_rsp_rdata[ADDR_W-1:0];
              go_rd = 1'b1;  rd_addr = cur_ptr + A_BUF;  rd_ph = P_BUF;
            end
            P_BUF: begin
              buf_n = mem_rsp_rdata[ADDR_W-1:0];
              if (sop_q) begin
                idx_n = '0;
                go_rd = 1'b1;  rd_addr = cur_ptr + A_APP;  rd_ph = P_APP;
              end else begin
                go_data = 1'b1;
              end
            end
            P_APP: begin
              cv_n = 1'b1;
              cd_n = mem_rsp_rdata;
              cl_n = (idx == APP_LAST);
              st_n = W_COUT;
            end
            default: begin
              dv_n = 1'b1;
              dd_n = mem_rsp_rdata;
              dk_n = fin ? tail_keep(len_q[1:0]) : 4'b1111;
              dl_n = fin && eop_q;
              st_n = W_DOUT;
            end
          endcase
        end
      end
      W_COUT: begin
        if (cout_ready) begin
          cv_n = 1'b0;
          cl_n = 1'b0;
          if (idx == APP_LAST) begin
            go_data = 1'b1;
          end else begin
            idx_n = idx_inc;
            go_rd = 1'b1;  rd_addr = cur_ptr + A_APP + word_off;  rd_ph = P_APP;
          end
        end
      end
      W_DOUT: begin
        if (dout_ready) begin
          dv_n = 1'b0;
          dl_n = 1'b0;
          if (fin) begin
            go_wb = 1'b1;
          end else begin
            idx_n = idx_inc;
            go_rd = 1'b1;  rd_addr = buf_q + word_off;  rd_ph = P_DATA;
          end
        end
      end
      default: begin // W_WB
        if (mem_req_ready) begin
          rv_n  = 1'b0;
          rwe_n = 1'b0;
          adv   = 1'b1;
          pd_n  = eop_q;
          if (at_tail) begin
            st_n = W_IDLE;
          end else begin
            go_rd = 1'b1;  rd_addr = nxt_q + A_STAT;  rd_ph = P_STAT;
          end
        end
      end
    endcase

    if (go_data) begin
      if (nwords != '0) begin
        idx_n = '0;
        go_rd = 1'b1;  rd_addr = buf_n;  rd_ph = P_DATA;
      end else begin
        go_wb = 1'b1;
      end
    end

    if (go_rd) begin
      rv_n = 1'b1;  rwe_n = 1'b0;  ra_n = rd_addr;  ph_n = rd_ph;  st_n = W_RD;
    end
    if (go_wb) begin
      rv_n  = 1'b1;
      rwe_n = 1'b1;
      ra_n  = cur_ptr + A_STAT;
      rwd_n = {1'b1, {(31-LEN_W){1'b0}}, len_q};
      st_n  = W_WB;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= W_IDLE;
      ph            <= P_STAT;
      idx           <= '0;
      len_q         <= '0;
      sop_q         <= 1'b0;
      eop_q         <= 1'b0;
      nxt_q         <= '0;
      buf_q         <= '0;
      mem_req_valid <= 1'b0;
      mem_req_we    <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
      dout_valid    <= 1'b0;
      dout_data     <= '0;
      dout_keep     <= '0;
      dout_last     <= 1'b0;
      cout_valid    <= 1'b0;
      cout_data     <= '0;
      cout_last     <= 1'b0;
      pkt_done      <= 1'b0;
    end else begin
      st            <= st_n;
      ph            <= ph_n;
      idx           <= idx_n;
      len_q         <= len_n;
      sop_q         <= sop_n;
      eop_q         <= eop_n;
      nxt_q         <= nxt_n;
      buf_q         <= buf_n;
      mem_req_valid <= rv_n;
      mem_req_we    <= rwe_n;
      mem_req_addr  <= ra_n;
      mem_req_wdata <= rwd_n;
      dout_valid    <= dv_n;
      dout_data     <= dd_n;
      dout_keep     <= dk_n;
      dout_last     <= dl_n;
      cout_valid    <= cv_n;
      cout_data     <= cd_n;
      cout_last     <= cl_n;
      pkt_done      <= pd_n;
    end
  end

  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    dout_valid && !dout_ready |=> dout_valid && $stable(dout_data) && $stable(dout_keep) && $stable(dout_last)); // R11

  AST_COUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    cout_valid && !cout_ready |=> cout_valid && $stable(cout_data) && $stable(cout_last)); // R11

  AST_ONE_STREAM: assert property (@(posedge clk) disable iff (rst)
    !(dout_valid && cout_valid)); // R4

  AST_KEEP_LOW: assert property (@(posedge clk) disable iff (rst)
    dout_valid |-> dout_keep[0]); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    pkt_done |=> !pkt_done); // R7

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)); // R8

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    halt_req |=> !mem_req_valid && !dout_valid && !cout_valid); // R3

endmodule

// File: rtl/sg_mm2s_engine.sv
module sg_mm2s_engine #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 23,
  parameter int APP_WORDS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_run,
  input  logic              cur_wr,
  input  logic [ADDR_W-1:0] cur_wdata,
  input  logic              tail_wr,
  input  logic [ADDR_W-1:0] tail_wdata,
  output logic [ADDR_W-1:0] cur_ptr,
  output logic              st_halted,
  output logic              st_idle,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_rdata,
  output logic              dout_valid,
  input  logic              dout_ready,
  output logic [31:0]       dout_data,
  output logic [3:0]        dout_keep,
  output logic              dout_last,
  output logic              cout_valid,
  input  logic              cout_ready,
  output logic [31:0]       cout_data,
  output logic              cout_last,
  output logic              pkt_done
);

  logic              adv, halt_req, at_tail, run_ok;
  logic [ADDR_W-1:0] adv_next;

  sg_chan_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_run    (cfg_run),
    .cur_wr     (cur_wr),
    .cur_wdata  (cur_wdata),
    .tail_wr    (tail_wr),
    .tail_wdata (tail_wdata),
    .adv        (adv),
    .adv_next   (adv_next),
    .halt_req   (halt_req),
    .cur_ptr    (cur_ptr),
    .at_tail    (at_tail),
    .run_ok     (run_ok),
    .halted     (st_halted),
    .idle       (st_idle)
  );

  sg_walker #(
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .APP_WORDS (APP_WORDS)
  ) u_walk (
    .clk           (clk),
    .rst           (rst),
    .run_ok        (run_ok),
    .at_tail       (at_tail),
    .cur_ptr       (cur_ptr),
    .adv           (adv),
    .adv_next      (adv_next),
    .halt_req      (halt_req),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_rdata (mem_rsp_rdata),
    .dout_valid    (dout_valid),
    .dout_ready    (dout_ready),
    .dout_data     (dout_data),
    .dout_keep     (dout_keep),
    .dout_last     (dout_last),
    .cout_valid    (cout_valid),
    .cout_ready    (cout_ready),
    .cout_data     (cout_data),
    .cout_last     (cout_last),
    .pkt_done      (pkt_done)
  );

endmodule

// File: tb/tb_sg_mm2s_engine.sv
module tb_sg_mm2s_engine;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr, cfg_run, cur_wr, tail_wr;
  logic [31:0] cur_wdata, tail_wdata, cur_ptr;
  logic        st_halted, st_idle;
  logic        mem_req_valid, mem_req_ready, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;
  logic        dout_valid, dout_ready, dout_last;
  logic [31:0] dout_data;
  logic [3:0]  dout_keep;
  logic        cout_valid, cout_ready, cout_last;
  logic [31:0] cout_data;
  logic        pkt_done;

  always #4 clk = ~clk; // 125 MHz

  sg_mm2s_engine dut (.*);

  logic [31:0] mem [0:2047];

  int checks = 0, errors = 0, cyc = 0;
  int beats = 0, ctrl_seen = 0, ctrl_total = 0, pkts = 0, exp_pkts = 0;
  int bp = 0, mem_bp = 0;
  bit prev_eof = 1'b1;

  logic [31:0] eq_data[$];
  logic [3:0]  eq_keep[$];
  logic        eq_last[$];
  int          eq_cb[$];
  logic [31:0] cq_data[$];
  logic        cq_last[$];
  int          st_addr[$];
  logic [31:0] st_val[$];

  bit          pend = 0, d_stall = 0, c_stall = 0;
  int          pend_cnt = 0;
  logic [31:0] pend_addr, d_hold, c_hold;
  logic        d_hold_last, c_hold_last;

  function automatic int da(input int i); return 32'h100 + i * 32'h40; endfunction
  function automatic int ba(input int i); return 32'h800 + i * 32'h40; endfunction
  function automatic logic [3:0] kexp(input int len);
    case (len % 4) 1: return 4'h1; 2: return 4'h3; 3: return 4'h7; default: return 4'hF; endcase
  endfunction
  function automatic bit pick(input int lvl);
    case (lvl) 0: return 1'b1; 1: return ($urandom % 2) == 0; default: return ($urandom % 4) == 0; endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Memory model, stream sinks and monitors, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (rst) begin
      mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_rdata = 0;
      dout_ready = 0; cout_ready = 0; pend = 0; d_stall = 0; c_stall = 0;
    end else begin
      mem_rsp_valid = 0;
      if (pend) begin
        if (pend_cnt == 0) begin
          mem_rsp_valid = 1; mem_rsp_rdata = mem[pend_addr[12:2]]; pend = 0;
        end else pend_cnt--;
      end
      mem_req_ready = pick(mem_bp);
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_we) mem[mem_req_addr[12:2]] = mem_req_wdata;
        else begin pend = 1; pend_cnt = $urandom % 3; pend_addr = mem_req_addr; end
      end
      // R11 stalled beats must persist unchanged
      if (d_stall) chk("R11 data beat held", {dout_valid, dout_last, dout_data}, {1'b1, d_hold_last, d_hold});
      if (c_stall) chk("R11 ctrl beat held", {cout_valid, cout_last, cout_data}, {1'b1, c_hold_last, c_hold});
      dout_ready = pick(bp);
      cout_ready = pick(bp);
      d_stall = dout_valid && !dout_ready; d_hold = dout_data; d_hold_last = dout_last;
      c_stall = cout_valid && !cout_ready; c_hold = cout_data; c_hold_last = cout_last;
      if (dout_valid && dout_ready) begin
        beats++;
        if (eq_data.size() == 0) chk("R5 unexpected data beat", 1, 0);
        else begin
          chk("R5 data word", dout_data, eq_data.pop_front());
          chk("R6 keep", dout_keep, eq_keep.pop_front());
          chk("R7 last", dout_last, eq_last.pop_front());
          chk("R4 ctrl before data", ctrl_seen >= eq_cb.pop_front(), 1);
        end
      end
      if (cout_valid && cout_ready) begin
        ctrl_seen++;
        if (cq_data.size() == 0) chk("R4 unexpected ctrl beat", 1, 0);
        else begin
          chk("R4 app word", cout_data, cq_data.pop_front());
          chk("R4 ctrl last", cout_last, cq_last.pop_front());
        end
      end
      if (pkt_done) pkts++;
    end
  end

  task automatic make_desc(input int i, input int len, input bit eof);
    bit sof;
    int b, nw;
    logic [31:0] w;
    sof = prev_eof;
    b = da(i) / 4;
    mem[b+0] = da(i + 1); mem[b+1] = 0; mem[b+2] = ba(i); mem[b+3] = 0;
    mem[b+4] = 0; mem[b+5] = 0;
    mem[b+6] = len | (32'(eof) << 26) | (32'(sof) << 27);
    mem[b+7] = 0;
    for (int a = 0; a < 5; a++) begin
      w = $urandom; mem[b+8+a] = w;
      if (sof) begin cq_data.push_back(w); cq_last.push_back(a == 4); ctrl_total++; end
    end
    nw = (len + 3) / 4;
    for (int k = 0; k < nw; k++) begin
      w = $urandom; mem[ba(i)/4 + k] = w;
      eq_data.push_back(w);
      eq_keep.push_back((k == nw - 1) ? kexp(len) : 4'hF);
      eq_last.push_back((k == nw - 1) && eof);
      eq_cb.push_back(ctrl_total);
    end
    st_addr.push_back(da(i) + 28);
    st_val.push_back(32'(len) | 32'h8000_0000);
    if (eof) exp_pkts++;
    prev_eof = eof;
  endtask

  task automatic do_cfg(input bit r);
    @(negedge clk); cfg_wr = 1; cfg_run = r;
    @(negedge clk); cfg_wr = 0;
  endtask
  task automatic do_cur(input int a);
    @(negedge clk); cur_wr = 1; cur_wdata = a;
    @(negedge clk); cur_wr = 0;
  endtask
  task automatic do_tail(input int a);
    @(negedge clk); tail_wr = 1; tail_wdata = a;
    @(negedge clk); tail_wr = 0;
  endtask

  task automatic wait_idle_and_check(input int exp_cur);
    int t = 0;
    repeat (4) @(negedge clk);
    while (!st_idle && t < 20000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk("R9 idle after tail", st_idle, 1);
    chk("R9 current pointer", cur_ptr, exp_cur);
    chk("R5 all data beats seen", eq_data.size(), 0);
    chk("R4 all ctrl beats seen", cq_data.size(), 0);
    chk("R7 packet pulses", pkts, exp_pkts);
    while (st_addr.size() > 0) begin
      int a = st_addr.pop_front();
      chk("R8 status writeback", mem[a/4], st_val.pop_front());
    end
  endtask

  initial begin
    int b0;
    void'($urandom(32'd2024));
    rst = 1; cfg_wr = 0; cfg_run = 0; cur_wr = 0; tail_wr = 0; cur_wdata = 0; tail_wdata = 0;
    for (int i = 0; i < 2048; i++) mem[i] = 0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 halted after reset", st_halted, 1);
    chk("R1 idle after reset", st_idle, 0);
    chk("R1 pointer after reset", cur_ptr, 0);
    chk("R1 no activity after reset", {mem_req_valid, dout_valid, cout_valid}, 0);

    // Directed: every keep pattern, packets spanning descriptors
    make_desc(0, 4, 1); make_desc(1, 1, 0); make_desc(2, 2, 0);
    make_desc(3, 3, 1); make_desc(4, 5, 1);
    do_cur(da(0)); do_tail(da(4));
    repeat (20) @(negedge clk);
    chk("R2 no walk while halted", beats, 0);
    do_cfg(1);
    chk("R2 run clears halted", st_halted, 0);
    wait_idle_and_check(da(5));

    // R12: run off, tail write must not start anything
    do_cfg(0);
    b0 = beats;
    prev_eof = 1;
    make_desc(0, 1 + $urandom % 40, 0); make_desc(1, 1 + $urandom % 40, 0);
    make_desc(2, 1 + $urandom % 40, 1);
    do_cur(da(0)); do_tail(da(2));
    repeat (80) @(negedge clk);
    chk("R12 no beats while run clear", beats, b0);
    chk("R12 pointer unchanged while run clear", cur_ptr, da(0));
    chk("R12 status untouched", mem[da(0)/4 + 7], 0);
    do_cfg(1);
    wait_idle_and_check(da(3));

    // R10: extend the chain and write a new tail
    make_desc(3, 1 + $urandom % 40, 1); make_desc(4, 1 + $urandom % 40, 0);
    make_desc(5, 1 + $urandom % 40, 1);
    do_tail(da(5));
    chk("R10 tail write clears idle", st_idle, 0);
    wait_idle_and_check(da(6));

    // R3: descriptor already complete
    b0 = beats;
    do_cur(da(0)); do_tail(da(3));
    repeat (60) @(negedge clk);
    chk("R3 halted on complete descriptor", st_halted, 1);
    chk("R3 pointer unchanged", cur_ptr, da(0));
    chk("R3 no beats", beats, b0);
    chk("R3 idle stays clear", st_idle, 0);

    // Random chains under increasing backpressure
    for (int r = 0; r < 3; r++) begin
      bp = r; mem_bp = r;
      prev_eof = 1;
      for (int i = 0; i < 8; i++) make_desc(i, 1 + $urandom % 40, (i == 7) || ($urandom % 2 == 0));
      do_cur(da(0)); do_tail(da(7)); do_cfg(1);
      wait_idle_and_check(da(8));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule